// File: doc/BRIEF.md
# Four-Channel Peripheral DMA Controller

The block moves data for peripherals without processor involvement. Four independent channels each hold a source address, a destination address, a 24-bit cycle count and a control word. Software fills these through a small register port and then sets the channel's enable bit. The channel then repeats transfer cycles until its count runs out, a bus error ends it, or software clears enable. Each side of a transfer can be paced by one of fifteen request/grant line pairs, so that a peripheral with a FIFO only sees accesses when it is ready.

A single shared engine serves the channels. It gives the bus to one channel for one transfer cycle at a time, and rotates among the enabled channels between cycles. Every beat of a cycle is a read from the source address followed by a write of the same data to the destination address. Both accesses go through one memory request port that uses a valid/ready handshake. The request and all its fields stay stable while `m_ready` is low, and `m_rdata` and `m_err` are sampled in the cycle the request is accepted. Completion and error conditions are kept in sticky status bits and merged into one interrupt line.

Top module: `pdma_ctrl`

## Requirements
- R1: Channel n (0 to 3) uses register address 16·n + 4·k, where k = 0 is the source address, 1 the destination address, 2 the cycle count and 3 the control word. The count keeps 24 bits. The control word keeps only its defined fields (mask 0x0F3F77FF), and every other bit reads back as 0. All registers reset to 0.
- R2: Control bit positions: 0 enable, 1 done status, 2 done-interrupt enable, 3 burst, 4 error status, 5 error-interrupt enable, 6 source on system bus, 7 destination on system bus, 10:8 source step code, 14:12 destination step code, 19:16 destination request line, 21:20 data width, 27:24 source request line.
- R3: A transfer cycle has one beat, or four beats when burst is set. Each beat is a read at the source address and then a write of the read data to the destination address. `m_size` carries the width field (00 word, 01 half-word, 10 byte). `m_sys` carries bit 6 on reads and bit 7 on writes.
- R4: After every beat, each address moves by the step of its code: 000 and 100 no step, 001 +1, 010 +2, 011 +4, 101 −1, 110 −2, 111 −4, all modulo 2^32. A burst cycle therefore moves an address by four times the step.
- R5: The count drops by one after each completed cycle. When it reaches 0, the done status is set and enable is cleared. Enabling a channel whose count is 0 sets done at once and makes no access.
- R6: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged. Status is set only by the hardware.
- R7: An error response on a read or a write sets the error status and clears enable. The failed read's write is not issued, and the count is not decremented.
- R8: Before each cycle, a side with a nonzero request line waits for `dreq[line]` and then pulses `dgnt[line]` for exactly one clock. The source side goes first. A side with line 0 does not wait. `dgnt[0]` is never driven, at most one grant is high at a time, and no grant is high while a memory request is pending.
- R9: `irq` is the OR over all channels of (done status AND done enable) OR (error status AND error enable).
- R10: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_write`, `m_wdata`, `m_size` and `m_sys` hold their values.
- R11: Channels are served one cycle at a time in round-robin order. The search for the next channel starts after the channel served last.
- R12: Clearing enable stops a channel at the next cycle boundary, or at once while it waits on a request line. No further grants or accesses occur, and the count is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte address (channel in 5:4, register in 3:2) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory request accepted this cycle |
| m_write | output | 1 | 1 for a write beat, 0 for a read beat |
| m_addr | output | 32 | Beat address |
| m_wdata | output | 32 | Write data |
| m_size | output | 2 | Beat width code |
| m_sys | output | 1 | 1 selects the system bus, 0 the peripheral bus |
| m_rdata | input | 32 | Read data, valid when a read is accepted |
| m_err | input | 1 | Error response, valid when a request is accepted |
| dreq | input | 16 | Request lines 1 to 15 (bit 0 unused) |
| dgnt | output | 16 | One-clock grant pulses, bit 0 always 0 |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets several corner cases. Descending burst steps would show up as wrong read addresses if the step were applied per cycle instead of per beat, or not sign-extended. An error on the read beat must suppress the matching write and leave the count alone; a design that wrote anyway would produce an unexpected write. A channel held on an unasserted request line must issue no grant even after the line rises once software has cleared enable; a design that did not recheck enable while waiting would grant late. Two channels started together, with the bus stalled, must alternate write by write; a fixed-priority engine would run one channel to completion first. A masked error status must keep `irq` low, and writing 1 to a set status bit must leave it set.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int EN_B    = 0;
  localparam int DONE_B  = 1;
  localparam int DIE_B   = 2;
  localparam int BURST_B = 3;
  localparam int ERR_B   = 4;
  localparam int EIE_B   = 5;
  localparam int SSYS_B  = 6;
  localparam int DSYS_B  = 7;
  localparam logic [31:0] CTL_MASK = 32'h0F3F_77FF;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SWAIT, S_SGNT, S_DWAIT, S_DGNT, S_RD, S_WR, S_NEXT
  } eng_st_e;

  typedef struct packed {
    logic        src_we;
    logic [31:0] src_val;
    logic        dst_we;
    logic [31:0] dst_val;
    logic        cnt_dec;
    logic        set_done;
    logic        set_err;
    logic        clr_en;
  } hw_upd_t;

  function automatic logic [31:0] step_of(input logic [2:0] code);
    case (code)
      3'b001:  return 32'd1;
      3'b010:  return 32'd2;
      3'b011:  return 32'd4;
      3'b101:  return 32'hFFFF_FFFF;
      3'b110:  return 32'hFFFF_FFFE;
      3'b111:  return 32'hFFFF_FFFC;
      default: return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CH_W+3:0]           cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic [CH_W-1:0]           hw_ch,
  input  hw_upd_t                   hw,
  output logic [NCH-1:0][31:0]      src_q,
  output logic [NCH-1:0][31:0]      dst_q,
  output logic [NCH-1:0][23:0]      cnt_q,
  output logic [NCH-1:0][31:0]      ctl_q
);
  logic [CH_W-1:0] sel_ch;
  logic [1:0]      sel_reg;
  assign sel_ch  = cfg_addr[CH_W+3:4];
  assign sel_reg = cfg_addr[3:2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic        sw_hit, hw_hit;
    logic [31:0] ctl_n;
    assign sw_hit = cfg_we && (sel_ch == CH_W'(c));
    assign hw_hit = (hw_ch == CH_W'(c));

    always_comb begin
      ctl_n = ctl_q[c];
      if (sw_hit && sel_reg == 2'd3) begin
        ctl_n         = cfg_wdata & CTL_MASK;
        ctl_n[DONE_B] = ctl_q[c][DONE_B] & cfg_wdata[DONE_B];
        ctl_n[ERR_B]  = ctl_q[c][ERR_B] & cfg_wdata[ERR_B];
      end
      if (hw_hit && hw.set_done) ctl_n[DONE_B] = 1'b1;
      if (hw_hit && hw.set_err)  ctl_n[ERR_B]  = 1'b1;
      if (hw_hit && hw.clr_en)   ctl_n[EN_B]   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[c] <= '0;
        dst_q[c] <= '0;
        cnt_q[c] <= '0;
        ctl_q[c] <= '0;
      end else begin
        if (sw_hit && sel_reg == 2'd0)  src_q[c] <= cfg_wdata;
        else if (hw_hit && hw.src_we)   src_q[c] <= hw.src_val;
        if (sw_hit && sel_reg == 2'd1)  dst_q[c] <= cfg_wdata;
        else if (hw_hit && hw.dst_we)   dst_q[c] <= hw.dst_val;
        if (sw_hit && sel_reg == 2'd2)  cnt_q[c] <= cfg_wdata[23:0];
        else if (hw_hit && hw.cnt_dec)  cnt_q[c] <= cnt_q[c] - 24'd1;
        ctl_q[c] <= ctl_n;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(sel_ch) < NCH) begin
      case (sel_reg)
        2'd0:    cfg_rdata = src_q[sel_ch];
        2'd1:    cfg_rdata = dst_q[sel_ch];
        2'd2:    cfg_rdata = {8'd0, cnt_q[sel_ch]};
        default: cfg_rdata = ctl_q[sel_ch];
      endcase
    end
  end
endmodule

// File: rtl/pdma_rr_arb.sv
module pdma_rr_arb #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  want,
  input  logic            take,
  output logic            gnt_valid,
  output logic [CH_W-1:0] gnt_idx
);
  logic [CH_W-1:0] last_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = (int'(last_q) + k) % NCH;
      if (!gnt_valid && want[j]) begin
        gnt_valid = 1'b1;
        gnt_idx   = CH_W'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 last_q <= CH_W'(NCH - 1);
    else if (take && gnt_valid) last_q <= gnt_idx;
  end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CH_W  = 2,
  parameter int NLINE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arb_valid,
  input  logic [CH_W-1:0]      arb_idx,
  output logic                 arb_take,
  input  logic [NCH-1:0][31:0] src_q,
  input  logic [NCH-1:0][31:0] dst_q,
  input  logic [NCH-1:0][23:0] cnt_q,
  input  logic [NCH-1:0][31:0] ctl_q,
  output logic [CH_W-1:0]      hw_ch,
  output hw_upd_t              hw,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic                 m_write,
  output logic [31:0]          m_addr,
  output logic [31:0]          m_wdata,
  output logic [1:0]           m_size,
  output logic                 m_sys,
  input  logic [31:0]          m_rdata,
  input  logic                 m_err,
  input  logic [NLINE-1:0]     dreq,
  output logic [NLINE-1:0]     dgnt
);
  eng_st_e         st_q, st_n;
  logic [CH_W-1:0] ch_q;
  logic [1:0]      beat_q;
  logic [31:0]     data_q;

  logic [31:0] ctl, src, dst;
  logic [23:0] cnt;
  logic [3:0]  sline, dline;
  logic        en, last_beat, acc;

  assign ctl       = ctl_q[ch_q];
  assign src       = src_q[ch_q];
  assign dst       = dst_q[ch_q];
  assign cnt       = cnt_q[ch_q];
  assign sline     = ctl[27:24];
  assign dline     = ctl[19:16];
  assign en        = ctl[EN_B];
  assign last_beat = ctl[BURST_B] ? (beat_q == 2'd3) : 1'b1;
  assign acc       = m_valid && m_ready;
  assign hw_ch     = ch_q;

  always_comb begin
    st_n     = st_q;
    arb_take = 1'b0;
    hw       = '0;
    m_valid  = 1'b0;
    m_write  = 1'b0;
    m_addr   = src;
    m_wdata  = data_q;
    m_size   = ctl[21:20];
    m_sys    = ctl[SSYS_B];
    dgnt     = '0;
    case (st_q)
      S_IDLE: if (arb_valid) begin
        arb_take = 1'b1;
        st_n     = S_START;
      end
      S_START: begin
        if (!en) st_n = S_IDLE;
        else if (cnt == 24'd0) begin
          hw.set_done = 1'b1;
          hw.clr_en   = 1'b1;
          st_n        = S_IDLE;
        end
        else if (sline != 4'd0) st_n = S_SWAIT;
        else if (dline != 4'd0) st_n = S_DWAIT;
        else                    st_n = S_RD;
      end
      S_SWAIT: begin
        if (!en)               st_n = S_IDLE;
        else if (dreq[sline])  st_n = S_SGNT;
      end
      S_SGNT: begin
        dgnt[sline] = 1'b1;
        st_n = (dline != 4'd0) ? S_DWAIT : S_RD;
      end
      S_DWAIT: begin
        if (!en)               st_n = S_IDLE;
        else if (dreq[dline])  st_n = S_DGNT;
      end
      S_DGNT: begin
        dgnt[dline] = 1'b1;
        st_n = S_RD;
      end
      S_RD: begin
        m_valid = 1'b1;
        if (acc) begin
          if (m_err) begin
            hw.set_err = 1'b1;
            hw.clr_en  = 1'b1;
            st_n       = S_IDLE;
          end else begin
            hw.src_we  = 1'b1;
            hw.src_val = src + step_of(ctl[10:8]);
            st_n       = S_WR;
          end
        end
      end
      S_WR: begin
        m_valid = 1'b1;
        m_write = 1'b1;
        m_addr  = dst;
        m_sys   = ctl[DSYS_B];
        if (acc) begin
          if (m_err) begin
            hw.set_err = 1'b1;
            hw.clr_en  = 1'b1;
            st_n       = S_IDLE;
          end else begin
            hw.dst_we  = 1'b1;
            hw.dst_val = dst + step_of(ctl[14:12]);
            st_n       = last_beat ? S_NEXT : S_RD;
          end
        end
      end
      S_NEXT: begin
        hw.cnt_dec = 1'b1;
        if (cnt == 24'd1) begin
          hw.set_done = 1'b1;
          hw.clr_en   = 1'b1;
        end
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ch_q   <= '0;
      beat_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_n;
      if (arb_take)                           ch_q   <= arb_idx;
      if (st_q == S_START)                    beat_q <= '0;
      else if (st_q == S_WR && acc && !m_err) beat_q <= beat_q + 2'd1;
      if (st_q == S_RD && acc)                data_q <= m_rdata;
    end
  end
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NLINE = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NCH)+3:0]   cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     m_write,
  output logic [31:0]              m_addr,
  output logic [31:0]              m_wdata,
  output logic [1:0]               m_size,
  output logic                     m_sys,
  input  logic [31:0]              m_rdata,
  input  logic                     m_err,
  input  logic [NLINE-1:0]         dreq,
  output logic [NLINE-1:0]         dgnt,
  output logic                     irq
);
  localparam int CH_W = $clog2(NCH);

  logic [NCH-1:0][31:0] src_q, dst_q, ctl_q;
  logic [NCH-1:0][23:0] cnt_q;
  logic [CH_W-1:0]      hw_ch, arb_idx;
  hw_upd_t              hw;
  logic                 arb_valid, arb_take;
  logic [NCH-1:0]       want;

  pdma_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_ch(hw_ch), .hw(hw),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ctl_q(ctl_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_want
    assign want[c] = ctl_q[c][EN_B];
  end

  pdma_rr_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .want(want), .take(arb_take),
    .gnt_valid(arb_valid), .gnt_idx(arb_idx)
  );

  pdma_engine #(.NCH(NCH), .CH_W(CH_W), .NLINE(NLINE)) u_eng (
    .clk(clk), .rst_n(rst_n), .arb_valid(arb_valid), .arb_idx(arb_idx),
    .arb_take(arb_take), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .ctl_q(ctl_q), .hw_ch(hw_ch), .hw(hw), .m_valid(m_valid),
    .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_size(m_size), .m_sys(m_sys), .m_rdata(m_rdata),
    .m_err(m_err), .dreq(dreq), .dgnt(dgnt)
  );

  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < NCH; c++)
      irq |= (ctl_q[c][DONE_B] & ctl_q[c][DIE_B]) |
             (ctl_q[c][ERR_B] & ctl_q[c][EIE_B]);
  end
endmodule

// File: rtl/pdma_ctrl_chk.sv
module pdma_ctrl_chk #(
  parameter int NLINE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m_valid,
  input logic             m_ready,
  input logic             m_write,
  input logic [31:0]      m_addr,
  input logic [31:0]      m_wdata,
  input logic [1:0]       m_size,
  input logic             m_sys,
  input logic             m_err,
  input logic [NLINE-1:0] dgnt
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write)
      && $stable(m_wdata) && $stable(m_size) && $stable(m_sys));

  // R7
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_err |=> !m_valid);

  // R8
  gnt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dgnt));

  // R8
  gnt_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dgnt[0]);

  // R8
  gnt_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dgnt) |-> !m_valid);
endmodule

bind pdma_ctrl pdma_ctrl_chk #(.NLINE(NLINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_size(m_size),
  .m_sys(m_sys), .m_err(m_err), .dgnt(dgnt)
);

// File: tb/tb_pdma_ctrl.sv
module tb_pdma_ctrl;
  typedef struct packed {
    logic        wr;
    logic        sys;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] data;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [5:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        m_valid, m_ready = 0, m_write, m_sys, m_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic [15:0] dreq = 0, dgnt;
  logic        irq;

  int errors = 0, checks = 0, accesses = 0;
  int gcnt [16];
  item_t exp_q [4][$];
  int wlog [$];
  logic stall = 0;
  logic [7:0] lfsr = 8'h5B;

  always #5 clk = ~clk;

  pdma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_valid(m_valid),
    .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_size(m_size), .m_sys(m_sys), .m_rdata(m_rdata),
    .m_err(m_err), .dreq(dreq), .dgnt(dgnt), .irq(irq)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_A5A5;
  endfunction
  assign m_rdata = mem_val(m_addr);
  assign m_err   = (m_addr[27:24] == 4'hE);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: drives ready, then scores the handshake the next edge will take
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_ready = stall ? 1'b0 : (lfsr[0] | lfsr[1]);
      for (int i = 0; i < 16; i++) if (dgnt[i]) gcnt[i]++;
      if (m_valid && m_ready) begin
        int c;
        item_t e, a;
        c = int'(m_addr[29:28]);
        a = '{m_write, m_sys, m_size, m_addr, m_write ? m_wdata : 32'd0};
        accesses++;
        if (m_write) wlog.push_back(c);
        if (exp_q[c].size() == 0) chk(0, "R3 unexpected access", m_addr, 32'd0);
        else begin
          e = exp_q[c].pop_front();
          if (!e.wr) e.data = 32'd0;
          chk(a == e, "R3/R4 access", a[63:32], e[63:32]);
          chk(a.data == e.data, "R3 data", a.data, e.data);
        end
      end
    end
  end

  task automatic reg_wr(input int ch, input int r, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(ch * 16 + r * 4); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic reg_rd(input int ch, input int r, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = 6'(ch * 16 + r * 4);
    #1 v = cfg_rdata;
  endtask

  // driver: queue the accesses a transfer must produce
  task automatic push_xfer(input int ch, input logic [31:0] s, input logic [31:0] ss,
                           input logic [31:0] d, input logic [31:0] ds, input int beats,
                           input logic [1:0] sz, input logic rsys, input logic wsys);
    for (int b = 0; b < beats; b++) begin
      exp_q[ch].push_back('{1'b0, rsys, sz, s, 32'd0});
      exp_q[ch].push_back('{1'b1, wsys, sz, d, mem_val(s)});
      s = s + ss; d = d + ds;
    end
  endtask

  task automatic wait_idle(input int ch);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(ch, 3, v);
      if (!v[0]) return;
    end
    chk(0, "R5 channel never stopped", v, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int a0;
    for (int i = 0; i < 16; i++) gcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      reg_rd(c, 3, v); chk(v == 0, "R1 ctl reset", v, 0);
    end
    reg_rd(0, 2, v); chk(v == 0, "R1 count reset", v, 0);
    chk(!irq && !m_valid, "R9 idle outputs", {irq, m_valid}, 0);

    // R1/R2 field mask and status write-1 behaviour
    reg_wr(3, 3, 32'hFFFF_FFFE);
    reg_rd(3, 3, v); chk(v == 32'h0F3F_77EC, "R1 ctl mask", v, 32'h0F3F_77EC);
    reg_wr(3, 2, 32'hFFFF_FFFF);
    reg_rd(3, 2, v); chk(v == 32'h00FF_FFFF, "R1 count width", v, 32'h00FF_FFFF);
    reg_wr(3, 0, 32'hFFFF_FFFF);
    reg_rd(3, 0, v); chk(v == 32'hFFFF_FFFF, "R1 src readback", v, 32'hFFFF_FFFF);
    reg_wr(3, 3, 0);

    // R3/R4/R5 single-beat +4 stepping, dest on system bus
    push_xfer(0, 32'h0000_1000, 4, 32'h0000_2000, 4, 3, 2'b00, 0, 1);
    reg_wr(0, 0, 32'h0000_1000); reg_wr(0, 1, 32'h0000_2000); reg_wr(0, 2, 3);
    reg_wr(0, 3, 32'h0000_3385);
    wait_idle(0);
    reg_rd(0, 3, v); chk(v[1] && !v[0], "R5 done set, enable cleared", v, 32'h3386);
    reg_rd(0, 2, v); chk(v == 0, "R5 count zero", v, 0);
    reg_rd(0, 0, v); chk(v == 32'h100C, "R4 src final", v, 32'h100C);
    reg_rd(0, 1, v); chk(v == 32'h200C, "R4 dst final", v, 32'h200C);
    chk(exp_q[0].size() == 0, "R3 all beats seen", exp_q[0].size(), 0);
    chk(irq, "R9 done irq", irq, 1);
    reg_wr(0, 3, 32'h0000_3386);
    reg_rd(0, 3, v); chk(v[1], "R6 write 1 keeps status", v, 32'h3386);
    reg_wr(0, 3, 0);
    reg_rd(0, 3, v); chk(v == 0, "R6 write 0 clears", v, 0);
    chk(!irq, "R9 irq low after clear", irq, 0);

    // R3/R4 burst, descending source, fixed destination, half-word
    push_xfer(1, 32'h1000_0100, 32'hFFFF_FFFC, 32'h1000_0800, 0, 8, 2'b01, 1, 0);
    reg_wr(1, 0, 32'h1000_0100); reg_wr(1, 1, 32'h1000_0800); reg_wr(1, 2, 2);
    reg_wr(1, 3, 32'h0010_074D);
    wait_idle(1);
    reg_rd(1, 0, v); chk(v == 32'h1000_00E0, "R4 burst src final", v, 32'h1000_00E0);
    reg_rd(1, 1, v); chk(v == 32'h1000_0800, "R4 fixed dst", v, 32'h1000_0800);
    chk(exp_q[1].size() == 0, "R3 burst beats", exp_q[1].size(), 0);
    reg_wr(1, 3, 0);

    // R8 pacing: source line 5 then destination line 9
    push_xfer(2, 32'h2000_0010, 1, 32'h2000_0400, 2, 2, 2'b10, 0, 0);
    reg_wr(2, 0, 32'h2000_0010); reg_wr(2, 1, 32'h2000_0400); reg_wr(2, 2, 2);
    a0 = accesses;
    reg_wr(2, 3, 32'h0529_2101);
    repeat (20) @(negedge clk);
    chk(accesses == a0 && gcnt[5] == 0, "R8 waits for request", accesses - a0, 0);
    dreq[5] = 1;
    repeat (10) @(negedge clk);
    chk(gcnt[5] == 1 && gcnt[9] == 0, "R8 source granted first", gcnt[9], 0);
    reg_rd(2, 2, v); chk(v == 2, "R8 count held while waiting", v, 2);
    dreq[9] = 1;
    wait_idle(2);
    chk(gcnt[5] == 2 && gcnt[9] == 2, "R8 one-clock grant per cycle", gcnt[9], 2);
    chk(exp_q[2].size() == 0, "R8 paced beats", exp_q[2].size(), 0);
    dreq = 0;
    reg_wr(2, 3, 0);

    // R7 read error: no write, count kept, error irq
    exp_q[3].push_back('{1'b0, 1'b0, 2'b00, 32'h3E00_0000, 32'd0});
    reg_wr(3, 0, 32'h3E00_0000); reg_wr(3, 1, 32'h3000_0100); reg_wr(3, 2, 5);
    reg_wr(3, 3, 32'h0000_0121);
    wait_idle(3);
    reg_rd(3, 3, v); chk(v[4], "R7 error status", v, 32'h130);
    reg_rd(3, 2, v); chk(v == 5, "R7 count kept", v, 5);
    chk(irq, "R9 error irq", irq, 1);
    chk(exp_q[3].size() == 0, "R7 read issued", exp_q[3].size(), 0);
    reg_wr(3, 3, 0);
    chk(!irq, "R9 irq cleared", irq, 0);

    // R7 write error with error interrupt masked
    push_xfer(3, 32'h3000_0000, 1, 32'h3E00_0040, 1, 1, 2'b00, 0, 0);
    reg_wr(3, 0, 32'h3000_0000); reg_wr(3, 1, 32'h3E00_0040);
    reg_wr(3, 3, 32'h0000_1101);
    wait_idle(3);
    reg_rd(3, 3, v); chk(v[4], "R7 write error status", v, 32'h1110);
    chk(!irq, "R9 masked error", irq, 0);
    reg_rd(3, 0, v); chk(v == 32'h3000_0001, "R7 src stepped", v, 32'h3000_0001);
    reg_rd(3, 1, v); chk(v == 32'h3E00_0040, "R7 dst unchanged", v, 32'h3E00_0040);
    reg_rd(3, 2, v); chk(v == 5, "R7 count after write error", v, 5);
    reg_wr(3, 3, 0);

    // R11 round robin, R10 stall
    push_xfer(1, 32'h1000_0000, 4, 32'h1000_0100, 4, 2, 2'b00, 0, 0);
    push_xfer(0, 32'h0000_0000, 4, 32'h0000_0100, 4, 2, 2'b00, 0, 0);
    reg_wr(1, 0, 32'h1000_0000); reg_wr(1, 1, 32'h1000_0100); reg_wr(1, 2, 2);
    reg_wr(0, 0, 32'h0000_0000); reg_wr(0, 1, 32'h0000_0100); reg_wr(0, 2, 2);
    wlog.delete();
    stall = 1;
    reg_wr(1, 3, 32'h0000_3301);
    repeat (5) @(negedge clk);
    chk(m_valid, "R10 request held under stall", m_valid, 1);
    reg_wr(0, 3, 32'h0000_3301);
    stall = 0;
    wait_idle(1); wait_idle(0);
    chk(wlog.size() == 4, "R11 write count", wlog.size(), 4);
    if (wlog.size() == 4)
      chk(wlog[0] == 1 && wlog[1] == 0 && wlog[2] == 1 && wlog[3] == 0,
          "R11 alternating order", {wlog[0][7:0], wlog[1][7:0], wlog[2][7:0], wlog[3][7:0]},
          32'h01000100);
    reg_wr(0, 3, 0); reg_wr(1, 3, 0);

    // R12 stop while waiting on a request line
    for (int i = 0; i < 16; i++) gcnt[i] = 0;
    a0 = accesses;
    reg_wr(2, 2, 4);
    reg_wr(2, 3, 32'h0600_0001);
    repeat (10) @(negedge clk);
    reg_wr(2, 3, 32'h0600_0000);
    dreq[6] = 1;
    repeat (20) @(negedge clk);
    chk(gcnt[6] == 0 && accesses == a0, "R12 no grant after stop", gcnt[6], 0);
    reg_rd(2, 2, v); chk(v == 4, "R12 count untouched", v, 4);
    reg_rd(2, 3, v); chk(v == 32'h0600_0000, "R12 no status", v, 32'h0600_0000);
    dreq = 0;

    // R5 zero count start
    a0 = accesses;
    reg_wr(3, 2, 0);
    reg_wr(3, 3, 32'h0000_0005);
    repeat (5) @(negedge clk);
    reg_rd(3, 3, v); chk(v == 32'h6, "R5 zero count done", v, 32'h6);
    chk(accesses == a0 && irq, "R5 no access, irq", accesses - a0, 0);
    reg_wr(3, 3, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule